// File: doc/BRIEF.md
# Command Queue Consumer Engine

This block empties a circular ring of commands held in memory. Software places 16-byte entries in the ring and moves a producer pointer forward. While the engine is enabled, no command-queue error is outstanding and the ring holds work, the engine fetches the entry at its consumer index one 32-bit word at a time. It decodes the opcode and retires the command. Only once retirement is done does it move its consumer pointer. Invalidation and prefetch opcodes are accepted as no-ops. A SYNC entry may ask for a completion interrupt.

An unknown opcode or a failed read stops the engine. The pointer stays on the faulting entry, a code goes into the error field of the consumer register, and a one-cycle global error interrupt fires. Work resumes once the system's global error flag and its acknowledge flag agree again. After each retirement the engine tests for emptiness again, so entries added while it was busy are drained too.

Top module: `cmdq_consumer`

## Requirements
- R1: The consumer pointer advances only after all four words of the entry have been returned and the command has been decoded and retired. It never moves during the fetch.
- R2: The consumer register holds the pointer with its wrap bit in bits [LOG2SIZE:0] and the error field in bits [30:24]. All other bits read 0. A pointer increment changes only bits [LOG2SIZE:0], modulo 2^(LOG2SIZE+1), and leaves the error field unchanged.
- R3: While `gerrFlag` and `gerrAckFlag` differ, no new command fetch is started.
- R4: The opcode is bits [7:0] of the entry's first word. Opcodes 0x01–0x07, 0x10–0x13, 0x18, 0x1A, 0x20–0x23, 0x28, 0x2A, 0x30, 0x40, 0x41, 0x44 and 0x45 retire with no other effect.
- R5: Opcode 0x46 (SYNC) retires normally. When bit 12 of its first word (bit 0 of the signal field in bits [13:12]) is set, `syncIrq` pulses high for one cycle, and the pointer advances on the next edge. Otherwise no interrupt is raised.
- R6: Any opcode not listed in R4 or R5, including 0x00, is illegal and gives error code 1.
- R7: A read returned with `rdErr` set aborts the command with error code 2.
- R8: On an error the pointer does not advance, the error code is written into bits [30:24], and `gerrIrq` pulses for exactly one cycle.
- R9: While `qEnable` is low, no fetch is started.
- R10: An entry is read as four single-word requests at `qBase + index*16 + 4*w`, for w = 0, 1, 2, 3 in order.
- R11: When several entries are pending, all of them are drained without further stimulus.
- R12: Reset clears the consumer register and leaves `rdReq`, `syncIrq` and `gerrIrq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| qEnable | input | 1 | Command queue enable |
| qBase | input | ADDR_W | Byte address of ring slot 0 |
| prodPtr | input | LOG2SIZE+1 | Producer index with wrap bit |
| gerrFlag | input | 1 | Command-queue bit of the global error register |
| gerrAckFlag | input | 1 | Command-queue bit of the global error acknowledge register |
| rdReq | output | 1 | Single-word read request |
| rdAddr | output | ADDR_W | Byte address of the requested word |
| rdValid | input | 1 | Read response valid |
| rdData | input | 32 | Read response data |
| rdErr | input | 1 | Read response failed |
| consReg | output | 32 | Consumer register: pointer and error field |
| syncIrq | output | 1 | SYNC completion interrupt pulse |
| gerrIrq | output | 1 | Global error interrupt pulse |

## Verification
A table walks one entry at a time through every class of opcode. It covers accepted no-ops at the edges of each legal range, SYNC with each value of the signal field, and illegal codes just beside the legal ranges. This separates decode slips from signal-field mistakes. Enough entries are walked that the pointer wraps, which exposes increment and wrap-bit faults. Directed cases follow: a burst of entries with an illegal one stuck ahead of a good one while the error stays unacknowledged, an aborted read, a disabled queue, and a cycle-level probe of when the pointer moves relative to the fourth read response. These tell the error path, the halt gating and the retirement timing apart.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  localparam logic [7:0] OP_SYNC = 8'h46;

  localparam logic [1:0] ERR_NONE    = 2'd0;
  localparam logic [1:0] ERR_ILLEGAL = 2'd1;
  localparam logic [1:0] ERR_ABORT   = 2'd2;

  localparam int ERR_LSB = 24;
  localparam int ERR_W   = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_WAIT, S_EXEC, S_ERR, S_HOLD
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       clrWord;
    logic       incWord;
    logic       capHead;
    logic       incCons;
    logic       setErr;
    logic [1:0] errCode;
  } strobe_t;

  function automatic logic opAccepted(input logic [7:0] op);
    case (op) inside
      [8'h01:8'h07], [8'h10:8'h13], 8'h18, 8'h1A,
      [8'h20:8'h23], 8'h28, 8'h2A, 8'h30,
      8'h40, 8'h41, 8'h44, 8'h45, OP_SYNC: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cmdq_datapath.sv
module cmdq_datapath
  import cmdq_pkg::*;
#(
  parameter int LOG2SIZE = 3,
  parameter int ADDR_W   = 32,
  parameter int WORDS    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [ADDR_W-1:0]   qBase,
  input  logic [LOG2SIZE:0]   prodPtr,
  input  logic [31:0]         rdData,
  output logic [31:0]         consReg,
  output logic [ADDR_W-1:0]   rdAddr,
  output logic [7:0]          opcode,
  output logic                syncSignal,
  output logic                qEmpty,
  output logic                lastWord
);
  localparam int PTR_W       = LOG2SIZE + 1;
  localparam int WIDX_W      = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int ENTRY_SHIFT = $clog2(WORDS * 4);

  logic [PTR_W-1:0]  consPtr;
  logic [ERR_W-1:0]  errField;
  logic [WIDX_W-1:0] wordIdx;
  logic [31:0]       headWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      consPtr  <= '0;
      errField <= '0;
      wordIdx  <= '0;
      headWord <= '0;
    end else begin
      if (stb.incCons) consPtr <= consPtr + 1'b1;
      if (stb.setErr)  errField <= ERR_W'(stb.errCode);
      if (stb.clrWord)      wordIdx <= '0;
      else if (stb.incWord) wordIdx <= wordIdx + 1'b1;
      if (stb.capHead && wordIdx == '0) headWord <= rdData;
    end
  end

  always_comb begin
    consReg = '0;
    consReg[PTR_W-1:0] = consPtr;
    consReg[ERR_LSB +: ERR_W] = errField;
  end

  assign rdAddr = qBase
                + (ADDR_W'(consPtr[LOG2SIZE-1:0]) << ENTRY_SHIFT)
                + (ADDR_W'(wordIdx) << 2);

  assign opcode     = headWord[7:0];
  assign syncSignal = headWord[12];
  assign qEmpty     = (consPtr == prodPtr);
  assign lastWord   = (wordIdx == WIDX_W'(WORDS - 1));

endmodule

// File: rtl/cmdq_control.sv
module cmdq_control
  import cmdq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    qEnable,
  input  logic    errPending,
  input  logic    qEmpty,
  input  logic    rdValid,
  input  logic    rdErr,
  input  logic    lastWord,
  input  logic [7:0] opcode,
  input  logic    syncSignal,
  output strobe_t stb,
  output logic    rdReq,
  output logic    syncIrq,
  output logic    gerrIrq
);
  state_e     state, stateNext;
  logic [1:0] errCodeQ, errCodeD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      errCodeQ <= ERR_NONE;
    end else begin
      state    <= stateNext;
      errCodeQ <= errCodeD;
    end
  end

  always_comb begin
    stateNext = state;
    errCodeD  = errCodeQ;
    stb       = '0;
    rdReq     = 1'b0;
    syncIrq   = 1'b0;
    gerrIrq   = 1'b0;
    case (state)
      S_IDLE: begin
        stb.clrWord = 1'b1;
        if (qEnable && !qEmpty && !errPending) stateNext = S_REQ;
      end
      S_REQ: begin
        rdReq     = 1'b1;
        stateNext = S_WAIT;
      end
      S_WAIT: begin
        if (rdValid) begin
          if (rdErr) begin
            errCodeD  = ERR_ABORT;
            stateNext = S_ERR;
          end else begin
            stb.capHead = 1'b1;
            if (lastWord) stateNext = S_EXEC;
            else begin
              stb.incWord = 1'b1;
              stateNext   = S_REQ;
            end
          end
        end
      end
      S_EXEC: begin
        if (opAccepted(opcode)) begin
          stb.incCons = 1'b1;
          syncIrq     = (opcode == OP_SYNC) && syncSignal;
          stateNext   = S_IDLE;
        end else begin
          errCodeD  = ERR_ILLEGAL;
          stateNext = S_ERR;
        end
      end
      S_ERR: begin
        stb.setErr  = 1'b1;
        stb.errCode = errCodeQ;
        gerrIrq     = 1'b1;
        stateNext   = S_HOLD;
      end
      S_HOLD: begin
        if (errPending) stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

endmodule

// File: rtl/cmdq_consumer.sv
module cmdq_consumer
  import cmdq_pkg::*;
#(
  parameter int LOG2SIZE = 3,
  parameter int ADDR_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                qEnable,
  input  logic [ADDR_W-1:0]   qBase,
  input  logic [LOG2SIZE:0]   prodPtr,
  input  logic                gerrFlag,
  input  logic                gerrAckFlag,
  output logic                rdReq,
  output logic [ADDR_W-1:0]   rdAddr,
  input  logic                rdValid,
  input  logic [31:0]         rdData,
  input  logic                rdErr,
  output logic [31:0]         consReg,
  output logic                syncIrq,
  output logic                gerrIrq
);
  strobe_t    stb;
  logic [7:0] opcode;
  logic       syncSignal, qEmpty, lastWord;

  cmdq_datapath #(.LOG2SIZE(LOG2SIZE), .ADDR_W(ADDR_W), .WORDS(4)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .qBase(qBase), .prodPtr(prodPtr),
    .rdData(rdData), .consReg(consReg), .rdAddr(rdAddr), .opcode(opcode),
    .syncSignal(syncSignal), .qEmpty(qEmpty), .lastWord(lastWord)
  );

  cmdq_control ctl_i (
    .clk(clk), .rstN(rstN), .qEnable(qEnable),
    .errPending(gerrFlag ^ gerrAckFlag), .qEmpty(qEmpty),
    .rdValid(rdValid), .rdErr(rdErr), .lastWord(lastWord),
    .opcode(opcode), .syncSignal(syncSignal), .stb(stb),
    .rdReq(rdReq), .syncIrq(syncIrq), .gerrIrq(gerrIrq)
  );

endmodule

// File: rtl/cmdq_consumer_chk.sv
module cmdq_consumer_chk #(
  parameter int LOG2SIZE = 3
) (
  input logic        clk,
  input logic        rstN,
  input logic        gerrFlag,
  input logic        gerrAckFlag,
  input logic        rdReq,
  input logic        rdValid,
  input logic        rdErr,
  input logic [31:0] consReg,
  input logic        syncIrq,
  input logic        gerrIrq
);
  localparam int PTR_W = LOG2SIZE + 1;

  logic [PTR_W-1:0] ptr, prevPtr;
  logic [6:0]       prevErr;
  logic [2:0]       okReads;
  logic             ptrMoved, pending;

  assign ptr      = consReg[PTR_W-1:0];
  assign ptrMoved = (ptr != prevPtr);
  assign pending  = gerrFlag ^ gerrAckFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevPtr <= '0;
      prevErr <= '0;
      okReads <= '0;
    end else begin
      prevPtr <= ptr;
      prevErr <= consReg[30:24];
      if (ptrMoved || gerrIrq)     okReads <= '0;
      else if (rdValid && !rdErr)  okReads <= okReads + 1'b1;
    end
  end

  assert_advance_after_fetch_R1: assert property (@(posedge clk) disable iff (!rstN)
    ptrMoved |-> okReads == 3'd4);

  assert_err_field_kept_R2: assert property (@(posedge clk) disable iff (!rstN)
    ptrMoved |-> consReg[30:24] == prevErr);

  assert_no_fetch_pending_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pending && $past(pending)) |-> !rdReq);

  assert_sync_then_advance_R5: assert property (@(posedge clk) disable iff (!rstN)
    syncIrq |=> ptr == $past(ptr) + 1'b1);

  assert_error_holds_ptr_R8: assert property (@(posedge clk) disable iff (!rstN)
    gerrIrq |=> (!gerrIrq && ptr == $past(ptr)));

endmodule

bind cmdq_consumer cmdq_consumer_chk #(.LOG2SIZE(LOG2SIZE)) chk_i (
  .clk(clk), .rstN(rstN), .gerrFlag(gerrFlag), .gerrAckFlag(gerrAckFlag),
  .rdReq(rdReq), .rdValid(rdValid), .rdErr(rdErr), .consReg(consReg),
  .syncIrq(syncIrq), .gerrIrq(gerrIrq)
);

// File: tb/cmdq_consumer_tb.sv
`timescale 1ns/1ps
module cmdq_consumer_tb_top;
  localparam int LOG2SIZE = 3;
  localparam int ADDR_W   = 32;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic qEnable = 1'b0;
  logic [LOG2SIZE:0] prodPtr = '0;
  logic gerrFlag = 1'b0, gerrAckFlag = 1'b0;
  logic rdReq, rdValid = 1'b0, rdErr = 1'b0;
  logic [ADDR_W-1:0] rdAddr;
  logic [31:0] rdData = '0, consReg;
  logic syncIrq, gerrIrq;

  always #2 clk = ~clk;

  cmdq_consumer #(.LOG2SIZE(LOG2SIZE), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .qEnable(qEnable), .qBase(BASE), .prodPtr(prodPtr),
    .gerrFlag(gerrFlag), .gerrAckFlag(gerrAckFlag), .rdReq(rdReq),
    .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData), .rdErr(rdErr),
    .consReg(consReg), .syncIrq(syncIrq), .gerrIrq(gerrIrq)
  );

  // memory model and event counters
  logic [31:0] headMem [8];
  logic        errSlotEn = 1'b0;
  logic [2:0]  errSlot = '0;
  logic [1:0]  wordCnt = '0;
  int reqCount = 0, syncCount = 0, gerrCount = 0, addrBad = 0;
  logic [2:0] reqSlot;
  logic [1:0] reqWord;
  assign reqSlot = rdAddr[6:4];
  assign reqWord = rdAddr[3:2];

  always_ff @(posedge clk) begin
    rdValid <= rdReq;
    rdErr   <= rdReq && errSlotEn && (reqSlot == errSlot);
    rdData  <= (reqWord == 2'd0) ? headMem[reqSlot] : {30'h3A5A_0000, reqWord};
    if (rdReq) begin
      reqCount <= reqCount + 1;
      wordCnt  <= wordCnt + 1'b1;
      if (rdAddr != BASE + {25'd0, consReg[2:0], 4'd0} + {28'd0, wordCnt, 2'd0})
        addrBad <= addrBad + 1;
    end
    if (gerrIrq) begin
      wordCnt   <= '0;
      gerrCount <= gerrCount + 1;
      gerrFlag  <= ~gerrAckFlag;
    end
    if (syncIrq) syncCount <= syncCount + 1;
  end

  int checks = 0, fails = 0;
  logic [3:0] expPtr = '0;
  logic [6:0] expErr = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pushCmd(input logic [7:0] op, input logic [1:0] cs);
    @(negedge clk);
    headMem[prodPtr[2:0]] = {18'd0, cs, 4'd0, op};
    prodPtr = prodPtr + 1'b1;
  endtask

  task automatic ack();
    @(negedge clk);
    gerrAckFlag = gerrFlag;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {opcode, cs, expect error, expect sync irq}
  localparam logic [11:0] VEC [19] = '{
    {8'h01, 2'd0, 1'b0, 1'b0}, {8'h07, 2'd0, 1'b0, 1'b0},
    {8'h10, 2'd0, 1'b0, 1'b0}, {8'h13, 2'd0, 1'b0, 1'b0},
    {8'h18, 2'd0, 1'b0, 1'b0}, {8'h1A, 2'd0, 1'b0, 1'b0},
    {8'h23, 2'd0, 1'b0, 1'b0}, {8'h2A, 2'd0, 1'b0, 1'b0},
    {8'h30, 2'd0, 1'b0, 1'b0}, {8'h41, 2'd0, 1'b0, 1'b0},
    {8'h45, 2'd0, 1'b0, 1'b0}, {8'h46, 2'd1, 1'b0, 1'b1},
    {8'h46, 2'd2, 1'b0, 1'b0}, {8'h46, 2'd3, 1'b0, 1'b1},
    {8'h00, 2'd0, 1'b1, 1'b0}, {8'h08, 2'd0, 1'b1, 1'b0},
    {8'h19, 2'd0, 1'b1, 1'b0}, {8'h47, 2'd0, 1'b1, 1'b0},
    {8'hFF, 2'd0, 1'b1, 1'b0}
  };

  logic finished = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int s0, g0, r0;
    for (int i = 0; i < 8; i++) headMem[i] = '0;
    settle(5);
    // R12 reset state
    check("R12 consReg", consReg, 32'd0);
    check("R12 rdReq", {29'd0, rdReq, syncIrq, gerrIrq}, 32'd0);
    rstN = 1'b1;

    // R9 disabled queue does not fetch
    pushCmd(8'h01, 2'd0);
    settle(30);
    check("R9 no request", reqCount, 0);
    check("R9 ptr held", consReg, 32'd0);
    qEnable = 1'b1;
    settle(30);
    expPtr = expPtr + 1'b1;
    check("R9 drains once enabled", consReg, {25'd0, expErr, 24'd0} | {28'd0, expPtr});

    // R1 pointer moves only after retirement
    pushCmd(8'h02, 2'd0);
    for (int k = 0; k < 4; k++) begin
      do @(negedge clk); while (!rdValid);
    end
    check("R1 ptr at last word", consReg[3:0], expPtr);
    @(negedge clk);
    check("R1 ptr during decode", consReg[3:0], expPtr);
    @(negedge clk);
    expPtr = expPtr + 1'b1;
    check("R1 ptr after retire", consReg[3:0], expPtr);

    // table of single entries (R4 R5 R6 R8 R2)
    for (int v = 0; v < 19; v++) begin
      s0 = syncCount; g0 = gerrCount;
      pushCmd(VEC[v][11:4], VEC[v][3:2]);
      settle(30);
      if (VEC[v][1]) begin
        check("R6 illegal code", consReg[30:24], 32'd1);
        check("R8 ptr held", consReg[3:0], expPtr);
        check("R8 gerr pulse", gerrCount, g0 + 1);
        expErr = 7'd1;
        headMem[expPtr[2:0]] = 32'h0000_0003;
        ack();
        settle(30);
        expPtr = expPtr + 1'b1;
        check("R2 err kept on advance", consReg, {1'b0, expErr, 24'd0} | {28'd0, expPtr});
      end else begin
        check("R4 retire", consReg, {1'b0, expErr, 24'd0} | {28'd0, expPtr + 1'b1});
        expPtr = expPtr + 1'b1;
        check("R5 sync irq count", syncCount, s0 + (VEC[v][0] ? 1 : 0));
        check("R4 no gerr", gerrCount, g0);
      end
    end

    // R11 burst drained
    pushCmd(8'h03, 2'd0); pushCmd(8'h11, 2'd0); pushCmd(8'h28, 2'd0);
    settle(60);
    expPtr = expPtr + 3'd3;
    check("R11 burst drained", consReg[3:0], expPtr);

    // R3 halt while error pending
    g0 = gerrCount;
    pushCmd(8'h00, 2'd0); pushCmd(8'h01, 2'd0);
    settle(40);
    check("R8 second error", gerrCount, g0 + 1);
    r0 = reqCount;
    settle(40);
    check("R3 no fetch while pending", reqCount, r0);
    check("R3 ptr held", consReg[3:0], expPtr);
    headMem[expPtr[2:0]] = 32'h0000_0004;
    ack();
    settle(60);
    expPtr = expPtr + 2'd2;
    check("R11 both drained after ack", consReg[3:0], expPtr);

    // R7 read abort
    g0 = gerrCount;
    errSlot = expPtr[2:0]; errSlotEn = 1'b1;
    pushCmd(8'h01, 2'd0);
    settle(30);
    check("R7 abort code", consReg[30:24], 32'd2);
    check("R8 ptr held on abort", consReg[3:0], expPtr);
    check("R8 gerr on abort", gerrCount, g0 + 1);
    errSlotEn = 1'b0;
    ack();
    settle(30);
    expPtr = expPtr + 1'b1;
    check("R2 abort code kept", consReg, {1'b0, 7'd2, 24'd0} | {28'd0, expPtr});

    check("R10 address order", addrBad, 0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule